// File: doc/BRIEF.md
# Interleaved Image Stream Selector

Several images can be packed into one byte stream by cutting each into fixed-size chunks and sending the chunks in turn: one chunk of the first image, one of the second, and so on, then back to the first. This block sits on such a stream and picks out one image. Every byte it accepts advances a position count. Bytes that fall in another image's chunks are accepted and dropped. Bytes of the chosen image pass out, in order and unchanged, on a valid/ready output.

While it forwards, the block compares the first thirteen forwarded bytes with a fixed signature and reports whether the image header is good or bad. The number of images and the chosen image are configuration inputs. They are latched by a one-cycle `restart` pulse, which also rewinds the position count and clears the output and the header verdict.

Top module: `ileave_pick`

## Requirements
- R1: After reset and before the first `restart`, `inReady`, `outValid`, `headerOk`, `headerBad` and `cfgError` are all 0.
- R2: `cfgCount` and `cfgSelect` are latched only in a cycle where `restart` is 1. Later changes to these inputs have no effect until the next `restart`.
- R3: Accepted bytes are numbered n = 0, 1, 2, ... from the last `restart`. Byte n belongs to image ((n / CHUNK_LEN) mod count) + 1, with CHUNK_LEN defaulting to 288. It is selected when that image number equals the latched select, which is 1-based.
- R4: Selected bytes appear on `outData` in arrival order with their values unchanged, one per `outValid && outReady` handshake.
- R5: Bytes that are not selected are accepted with `inReady` 1 and never appear on the output.
- R6: After the first `restart`, `inReady` is 0 only in a `restart` cycle, or when the current byte is selected while `outValid` is 1 and `outReady` is 0.
- R7: While `outValid` is 1 and `outReady` is 0, `outValid` stays 1 and `outData` holds its value in the next cycle.
- R8: The first 13 selected bytes are compared with 00 09 0F F0 0F F0 0F F0 0F F0 00 00 01, in that order. In the cycle after the 13th selected byte is accepted, exactly one of the flags rises: `headerOk` if all 13 bytes match, otherwise `headerBad`. The flag that rose holds until the next `restart`.
- R9: A latched select of 0, or one greater than the latched count, sets `cfgError` from the cycle after `restart`. In that state all bytes are accepted and none is forwarded.
- R10: In the cycle after `restart`, `outValid`, `headerOk` and `headerBad` are 0, and any byte that was waiting on the output is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Latches the configuration and rewinds the stream position |
| cfgCount | input | IDX_W | Number of interleaved images |
| cfgSelect | input | IDX_W | Image to extract, 1-based |
| inValid | input | 1 | Input byte valid |
| inData | input | 8 | Input byte |
| inReady | output | 1 | Input byte accepted when high together with inValid |
| outValid | output | 1 | Output byte valid |
| outData | output | 8 | Output byte of the selected image |
| outReady | input | 1 | Downstream accepts the output byte |
| headerOk | output | 1 | Signature of the selected image matched |
| headerBad | output | 1 | Signature of the selected image mismatched |
| cfgError | output | 1 | Latched select is outside 1..count |

## Verification
The bench uses a small chunk length, so the chunk boundaries and the wrap from the last image back to the first come up many times in every run. It sweeps every count from 1 to 4 against every legal select, under both free-flowing and stalling handshakes. A design that got the wrap or the division wrong would forward bytes of a neighbouring image, and the compare against the arithmetically computed byte order shows this at once. Corrupting the first, a middle and the last signature byte checks that the verdict is bad and that it appears exactly one cycle after the 13th selected byte, including when the header spans several chunks. Out-of-range selects, restarts that land with a byte stalled on the output, and configuration inputs that change after a restart check that dropped bytes are never blocked and that stale state does not survive.

// File: rtl/ileave_pick_pkg.sv
package ileave_pick_pkg;

  localparam int SIG_LEN = 13;

  typedef struct packed {
    logic load;   // restart: latch config, clear state
    logic take;   // a byte is accepted from the input
    logic pass;   // the accepted byte belongs to the selected image
  } strobe_t;

  function automatic logic [7:0] sigByte(input logic [3:0] idx);
    logic [7:0] v;
    case (idx)
      4'd0, 4'd10, 4'd11: v = 8'h00;
      4'd1:               v = 8'h09;
      4'd2, 4'd4, 4'd6, 4'd8: v = 8'h0F;
      4'd3, 4'd5, 4'd7, 4'd9: v = 8'hF0;
      4'd12:              v = 8'h01;
      default:            v = 8'h00;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/ileave_pick_ctrl.sv
module ileave_pick_ctrl
  import ileave_pick_pkg::*;
#(
  parameter int CHUNK_LEN = 288,
  parameter int IDX_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [IDX_W-1:0] cfgCount,
  input  logic [IDX_W-1:0] cfgSelect,
  input  logic             inValid,
  input  logic             outValid,
  input  logic             outReady,
  output logic             inReady,
  output logic             cfgError,
  output strobe_t          stb
);

  localparam int POS_W = (CHUNK_LEN > 1) ? $clog2(CHUNK_LEN) : 1;
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(CHUNK_LEN - 1);

  logic             armed;
  logic             errReg;
  logic [IDX_W-1:0] cntReg;
  logic [IDX_W-1:0] selReg;
  logic [POS_W-1:0] chunkPos;
  logic [IDX_W-1:0] imgIdx;

  logic [IDX_W:0] imgNum;
  logic           lastImg;
  logic           selNow;
  logic           take;

  assign imgNum  = {1'b0, imgIdx} + (IDX_W+1)'(1);
  assign lastImg = imgNum >= {1'b0, cntReg};
  assign selNow  = armed && !errReg && (imgNum == {1'b0, selReg});

  assign inReady  = armed && !restart && (!selNow || !outValid || outReady);
  assign take     = inValid && inReady;
  assign cfgError = errReg;

  assign stb.load = restart;
  assign stb.take = take;
  assign stb.pass = take && selNow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      errReg   <= 1'b0;
      cntReg   <= '0;
      selReg   <= '0;
      chunkPos <= '0;
      imgIdx   <= '0;
    end else if (restart) begin
      armed    <= 1'b1;
      cntReg   <= cfgCount;
      selReg   <= cfgSelect;
      errReg   <= (cfgSelect == '0) || (cfgSelect > cfgCount);
      chunkPos <= '0;
      imgIdx   <= '0;
    end else if (take) begin
      if (chunkPos == POS_LAST) begin
        chunkPos <= '0;
        imgIdx   <= lastImg ? '0 : imgIdx + IDX_W'(1);
      end else begin
        chunkPos <= chunkPos + POS_W'(1);
      end
    end
  end

endmodule

// File: rtl/ileave_pick_dp.sv
module ileave_pick_dp
  import ileave_pick_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  strobe_t    stb,
  input  logic [7:0] inData,
  input  logic       outReady,
  output logic       outValid,
  output logic [7:0] outData,
  output logic       headerOk,
  output logic       headerBad
);

  logic [3:0] hdrCnt;
  logic       badSeen;
  logic       miss;
  logic       hdrOpen;
  logic       hdrLast;

  assign hdrOpen = hdrCnt < 4'(SIG_LEN);
  assign hdrLast = hdrCnt == 4'(SIG_LEN - 1);
  assign miss    = inData != sigByte(hdrCnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else if (stb.load) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else if (stb.pass) begin
      outValid <= 1'b1;
      outData  <= inData;
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdrCnt    <= '0;
      badSeen   <= 1'b0;
      headerOk  <= 1'b0;
      headerBad <= 1'b0;
    end else if (stb.load) begin
      hdrCnt    <= '0;
      badSeen   <= 1'b0;
      headerOk  <= 1'b0;
      headerBad <= 1'b0;
    end else if (stb.pass && hdrOpen) begin
      hdrCnt  <= hdrCnt + 4'd1;
      badSeen <= badSeen | miss;
      if (hdrLast) begin
        headerOk  <= !(badSeen || miss);
        headerBad <= badSeen || miss;
      end
    end
  end

endmodule

// File: rtl/ileave_pick.sv
module ileave_pick
  import ileave_pick_pkg::*;
#(
  parameter int CHUNK_LEN = 288,
  parameter int IDX_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [IDX_W-1:0] cfgCount,
  input  logic [IDX_W-1:0] cfgSelect,
  input  logic             inValid,
  input  logic [7:0]       inData,
  output logic             inReady,
  output logic             outValid,
  output logic [7:0]       outData,
  input  logic             outReady,
  output logic             headerOk,
  output logic             headerBad,
  output logic             cfgError
);

  strobe_t stb;

  ileave_pick_ctrl #(
    .CHUNK_LEN(CHUNK_LEN),
    .IDX_W    (IDX_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .cfgCount (cfgCount),
    .cfgSelect(cfgSelect),
    .inValid  (inValid),
    .outValid (outValid),
    .outReady (outReady),
    .inReady  (inReady),
    .cfgError (cfgError),
    .stb      (stb)
  );

  ileave_pick_dp u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (stb),
    .inData   (inData),
    .outReady (outReady),
    .outValid (outValid),
    .outData  (outData),
    .headerOk (headerOk),
    .headerBad(headerBad)
  );

endmodule

// File: rtl/ileave_pick_chk.sv
module ileave_pick_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       restart,
  input logic       outValid,
  input logic [7:0] outData,
  input logic       outReady,
  input logic       headerOk,
  input logic       headerBad,
  input logic       cfgError
);

  // R7
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady && !restart) |=> (outValid && $stable(outData)));

  // R8
  verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(headerOk && headerBad));

  // R8
  verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((headerOk || headerBad) && !restart) |=> (headerOk || headerBad));

  // R9
  err_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfgError |-> !outValid);

  // R10
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!outValid && !headerOk && !headerBad));

endmodule

bind ileave_pick ileave_pick_chk u_chk (.*);

// File: tb/sim_ileave_pick.sv
module sim_ileave_pick;

  localparam int C  = 5;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          restart = 1'b0;
  logic [IW-1:0] cfgCount = '0;
  logic [IW-1:0] cfgSelect = '0;
  logic          inValid = 1'b0;
  logic [7:0]    inData = '0;
  logic          inReady;
  logic          outValid;
  logic [7:0]    outData;
  logic          outReady = 1'b0;
  logic          headerOk;
  logic          headerBad;
  logic          cfgError;

  int nChk = 0;
  int nBad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ileave_pick #(.CHUNK_LEN(C), .IDX_W(IW)) u0 (.*);

  function automatic logic [7:0] sigv(int k);
    logic [7:0] t [13] = '{8'h00, 8'h09, 8'h0F, 8'hF0, 8'h0F, 8'hF0, 8'h0F,
                           8'hF0, 8'h0F, 8'hF0, 8'h00, 8'h00, 8'h01};
    return t[k];
  endfunction

  // value of the k-th byte of image img (0-based)
  function automatic logic [7:0] imgByte(int k, int img, int selImg, int badK);
    if (img == selImg) begin
      if (k < 13) return sigv(k) ^ ((k == badK) ? 8'h5A : 8'h00);
      return 8'((k * 37 + img * 11 + 3) & 255);
    end
    return 8'((k * 37 + img * 11 + 3) & 255) ^ 8'hC3;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doRestart(int n, int sel);
    @(negedge clk);
    cfgCount  = IW'(n);
    cfgSelect = IW'(sel);
    restart   = 1'b1;
    inValid   = 1'b1;
    @(negedge clk);
    restart   = 1'b0;
    cfgCount  = IW'(7 - n);      // R2: later changes must be ignored
    cfgSelect = IW'(n + 1 - sel);
    #1;
    chk(!outValid, "R10 outValid", int'(outValid), 0);
    chk(!headerOk && !headerBad, "R10 flags", int'({headerOk, headerBad}), 0);
  endtask

  // one extraction run; mode 1 throttles both sides
  task automatic run(int n, int sel, int mode, int badK, int target);
    int g = 0, outCnt = 0, selCnt = 0, cyc = 0;
    bit hdrDone = 0, stall = 0;
    logic [7:0] held = '0;
    doRestart(n, sel);
    chk(cfgError == 1'b0, "R9 legal select", int'(cfgError), 0);
    while (outCnt < target && cyc < 3000) begin
      int img, k;
      bit selG;
      if (cyc != 0) @(negedge clk);
      img = (g / C) % n;
      k   = (g / (C * n)) * C + g % C;
      selG = (img == sel - 1);
      inValid  = (mode == 0) ? 1'b1 : ((cyc % 3) != 1);
      outReady = (mode == 0) ? 1'b1 : ((cyc % 4) < 2);
      inData   = imgByte(k, img, sel - 1, badK);
      #1;
      if (stall) chk(outValid && outData == held, "R7 hold", int'(outData), int'(held));
      if (!selG) chk(inReady == 1'b1, "R5 drop accepted", int'(inReady), 1);
      else if (outValid && !outReady) chk(inReady == 1'b0, "R6 backpressure", int'(inReady), 0);
      else chk(inReady == 1'b1, "R6 ready", int'(inReady), 1);
      chk(headerOk == (hdrDone && badK > 12), "R8 ok flag", int'(headerOk), int'(hdrDone && badK > 12));
      chk(headerBad == (hdrDone && badK <= 12), "R8 bad flag", int'(headerBad), int'(hdrDone && badK <= 12));
      stall = outValid && !outReady;
      held  = outData;
      if (outValid && outReady) begin
        logic [7:0] e;
        e = imgByte(outCnt, sel - 1, sel - 1, badK);
        chk(outData == e, "R3 R4 data order", int'(outData), int'(e));
        outCnt++;
      end
      if (inValid && inReady) begin
        if (selG) begin
          selCnt++;
          if (selCnt == 13) hdrDone = 1;
        end
        g++;
      end
      cyc++;
    end
    chk(outCnt == target, "R4 count", outCnt, target);
  endtask

  task automatic errRun(int n, int sel);
    doRestart(n, sel);
    chk(cfgError == 1'b1, "R9 error flag", int'(cfgError), 1);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      inValid = 1'b1; outReady = 1'b1; inData = 8'(i);
      #1;
      chk(inReady && !outValid, "R9 drain silently", int'({inReady, outValid}), 2);
    end
  endtask

  initial begin
    #3;
    inValid = 1'b1;
    #20;
    chk(!inReady && !outValid && !headerOk && !headerBad && !cfgError, "R1 reset",
        int'({inReady, outValid, headerOk, headerBad, cfgError}), 0);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    #1;
    chk(!inReady && !outValid && !cfgError, "R1 idle before restart",
        int'({inReady, outValid, cfgError}), 0);
    for (int n = 1; n <= 4; n++)
      for (int s = 1; s <= n; s++)
        for (int m = 0; m < 2; m++)
          run(n, s, m, 99, 30);
    run(3, 2, 1, 0, 20);
    run(3, 3, 0, 6, 20);
    run(2, 1, 1, 12, 20);
    run(4, 4, 1, 99, 6);   // stopped mid-stream; next restart must clear it
    @(negedge clk); outReady = 1'b0; inValid = 1'b1;
    run(2, 2, 0, 99, 20);
    errRun(3, 0);
    errRun(2, 3);
    run(1, 1, 1, 99, 15);  // recovery after error
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1'b1;
      nChk++; nBad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

endmodule